// File: doc/BRIEF.md
# Two-Wire Bus Stall Watchdog

This block sits beside a two-wire serial slave and watches its already synchronized clock and data lines. It counts system clock cycles while at least one of the two lines is low. The count goes back to zero only in a cycle where both lines are high together. The low periods of the two lines are therefore merged into one measurement, and a bus where the clock and data lines take turns holding low still runs out the limit.

When the count reaches the configured limit, the block issues a single-cycle reset pulse to the companion slave state machine, which returns it to idle. At the same time it sets a sticky flag that stays set until the system reset. After it fires, the watchdog stays quiet until the bus has been released, meaning both lines are seen high. Only then can a new stall be measured. The limit is a parameter in system clock cycles; for example, 66 ms at 50 MHz is 3,300,000 cycles.

Top module: `bus_stall_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fsm_rst_pulse` and `stall_seen` are both 0.
- R2: A cycle counts as low when `scl_sync` is 0 or `sda_sync` is 0. After exactly `LIMIT_CYCLES` consecutive low cycles, sampled at rising edges, `fsm_rst_pulse` is 1 following the edge that samples the last of them. It is not 1 after fewer.
- R3: Holding only `scl_sync` low, only `sda_sync` low, or both low each lead to expiry after the same `LIMIT_CYCLES` low cycles.
- R4: `fsm_rst_pulse` is high for exactly one cycle per expiry.
- R5: `stall_seen` becomes 1 together with the pulse. It stays 1 whatever the lines do until `rst_n` goes low, which clears it.
- R6: After an expiry, continued low cycles produce no further pulse until a cycle with both lines high has been sampled.
- R7: A single sampled cycle with both lines high clears the accumulated count. A following stall needs a full `LIMIT_CYCLES` low cycles again.
- R8: Low cycles on `scl_sync` and `sda_sync` that alternate, with no sampled cycle where both are high, add up into one count and trigger expiry.
- R9: A cycle in which both lines are high is never followed by a pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_sync | input | 1 | Synchronized serial clock line |
| sda_sync | input | 1 | Synchronized serial data line |
| fsm_rst_pulse | output | 1 | One-cycle reset to the slave state machine on expiry |
| stall_seen | output | 1 | Sticky flag, set on expiry, cleared by reset |

## Verification
The bench builds the block with `LIMIT_CYCLES` set to 8 instead of the multi-million default. This makes the exact expiry edge, one cycle short of it, and repeated stalls all reachable in a few hundred cycles. With this small limit the bench can count every low cycle by hand. It can place the single both-high cycle at any point in a stall, interleave clock-low and data-low stretches, and check how the watchdog re-arms, all against counts worked out directly from the requirements.

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
  parameter int LIMIT_CYCLES = 3_300_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_sync,
  input  logic sda_sync,
  output logic fsm_rst_pulse,
  output logic stall_seen
);
  localparam int CNT_W = (LIMIT_CYCLES > 2) ? $clog2(LIMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_CYCLES - 1);

  logic [CNT_W-1:0] low_cnt;
  logic             armed;
  logic             bus_low;
  logic             expire;

  assign bus_low = !scl_sync || !sda_sync;
  assign expire  = armed && bus_low && (low_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt       <= '0;
      armed         <= 1'b1;
      fsm_rst_pulse <= 1'b0;
      stall_seen    <= 1'b0;
    end else begin
      fsm_rst_pulse <= expire;
      if (!bus_low) begin
        low_cnt <= '0;
        armed   <= 1'b1;
      end else if (expire) begin
        low_cnt    <= '0;
        armed      <= 1'b0;
        stall_seen <= 1'b1;
      end else if (armed) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst_pulse |=> !fsm_rst_pulse);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_seen |=> stall_seen);

  p_pulse_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst_pulse |-> stall_seen);

  p_release_blocks_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_sync && sda_sync) |=> !fsm_rst_pulse);

  p_no_rearm_while_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_rst_pulse && !scl_sync) |=> !fsm_rst_pulse);

  initial begin
    a_limit_min: assert (LIMIT_CYCLES >= 2);
  end
endmodule

// File: tb/bus_stall_watchdog_tb_top.sv
`timescale 1ns/1ps
module bus_stall_watchdog_tb_top;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic pulse;
  logic flag;
  int   n_checks = 0;
  int   n_errors = 0;

  always #10 clk = ~clk;

  bus_stall_watchdog #(.LIMIT_CYCLES(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl), .sda_sync(sda),
    .fsm_rst_pulse(pulse), .stall_seen(flag)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // drive at the falling edge, let one rising edge sample, look 5 ns later
  task automatic step(input logic s_c, input logic s_d);
    @(negedge clk);
    scl = s_c;
    sda = s_d;
    @(posedge clk);
    #5;
  endtask

  task automatic hold(input logic s_c, input logic s_d, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(s_c, s_d);
      check(pulse, 1'b0, req, "no pulse during hold");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    scl = 1'b1;
    sda = 1'b1;
    #3;
    check(pulse, 1'b0, "R1", "pulse in reset");
    check(flag, 1'b0, "R1", "flag in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1);
    check(pulse, 1'b0, "R1", "pulse after reset");
    check(flag, 1'b0, "R1", "flag after reset");
  endtask

  task automatic t_scl_stall();
    hold(1'b0, 1'b1, LIM - 1, "R2");
    check(flag, 1'b0, "R2", "flag before limit");
    step(1'b0, 1'b1);
    check(pulse, 1'b1, "R2", "pulse at limit");
    check(flag, 1'b1, "R5", "flag set with pulse");
    step(1'b0, 1'b1);
    check(pulse, 1'b0, "R4", "pulse one cycle only");
    hold(1'b0, 1'b1, 3 * LIM, "R6");
    check(flag, 1'b1, "R5", "flag holds while low");
  endtask

  task automatic t_rearm_sda();
    step(1'b1, 1'b1);
    check(pulse, 1'b0, "R9", "no pulse after release");
    check(flag, 1'b1, "R5", "flag holds after release");
    hold(1'b1, 1'b0, LIM - 1, "R3");
    step(1'b1, 1'b0);
    check(pulse, 1'b1, "R3", "sda-only stall fires");
    step(1'b1, 1'b1);
    check(pulse, 1'b0, "R4", "pulse gone");
  endtask

  task automatic t_both_low();
    hold(1'b0, 1'b0, LIM - 1, "R3");
    step(1'b0, 1'b0);
    check(pulse, 1'b1, "R3", "both-low stall fires");
    step(1'b1, 1'b1);
  endtask

  task automatic t_alternate();
    hold(1'b0, 1'b1, 3, "R8");
    hold(1'b1, 1'b0, 2, "R8");
    hold(1'b0, 1'b1, 2, "R8");
    step(1'b1, 1'b0);
    check(pulse, 1'b1, "R8", "alternating lows add up");
    step(1'b1, 1'b1);
  endtask

  task automatic t_clear();
    hold(1'b0, 1'b1, LIM - 2, "R7");
    step(1'b1, 1'b1);
    check(pulse, 1'b0, "R7", "release mid-stall");
    hold(1'b1, 1'b0, LIM - 1, "R7");
    check(pulse, 1'b0, "R7", "count restarted");
    step(1'b0, 1'b0);
    check(pulse, 1'b1, "R7", "fires after full limit");
    step(1'b1, 1'b1);
  endtask

  task automatic t_flag_reset();
    check(flag, 1'b1, "R5", "flag still set");
    do_reset();
  endtask

  initial begin
    #(200 * LIM * 20 * 10);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    t_scl_stall();
    t_rearm_sda();
    t_both_low();
    t_alternate();
    t_clear();
    t_flag_reset();
    t_alternate();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule